// File: doc/BRIEF.md
# Multi-Channel Thermal Sampling Sequencer

This block drives up to four on-die temperature sensor channels through one shared converter. Software programs it through a small word-addressed register file: how long each acquisition lasts, the spacing between conversions, how many conversions are averaged, which channels take part, and how often a full measurement round starts. When a round starts, the block visits every enabled channel in ascending index order. For each channel it runs the configured number of acquire-and-convert cycles and averages the codes. It then applies a per-channel calibration offset and stores a 12-bit result.

A stored result sets that channel's bit in a write-one-to-clear status register. A single interrupt line goes high whenever a status bit is set and its enable bit is also set. The converter is reached through a plain handshake. The block pulses a start request with a channel number, and the converter answers with a done strobe and a 12-bit raw code.

Top module: `therm_seq_ctrl`

## Requirements
- R1: After reset, word 0 reads 0x01DF002F, the calibration words (8 and 9) read 0x08000800, the status word (5) reads 0, the result words (16+i) read 0, and irq_o is low.
- R2: Word 0 holds the acquisition length minus one in bits [15:0] and the conversion spacing minus one in bits [31:16]. A conversion request is raised after acquisition_m1+1 cycles of acquisition. Successive acquisitions within a round start exactly spacing_m1+1 cycles apart whenever the conversion finishes sooner.
- R3: Word 3 bit 2 enables averaging, and bits [1:0] select the sample count 2^(type+1). With averaging off, one sample is taken. The averaged code is the sum shifted right by log2 of the count.
- R4: Word 2 bits [31:12] hold an interval field F. While any channel is enabled, rounds start every (F+1)·2^UNIT_LOG2·samples cycles.
- R5: Word 1 bit i enables channel i. A round converts the enabled channels in ascending order and skips the others. The result word of a disabled channel keeps its value.
- R6: Channel i's 12-bit calibration value sits in word 8+i/2 at bit 16·(i mod 2). The stored result is avg + cal − 0x800, clamped to the range 0..0xFFF.
- R7: A new result for channel i sets bit i of word 5. Writing 1 to bit i clears it, and writing 0 leaves it alone. When a clear and a new result coincide, the bit ends up set.
- R8: irq_o is high exactly when some bit of word 5 is set and the same bit of word 4 is set.
- R9: conv_start_o is a one-cycle pulse, and conv_chan_o holds its value in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | AW | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| conv_start_o | output | 1 | Conversion request pulse |
| conv_chan_o | output | CHW | Channel being converted |
| conv_done_i | input | 1 | Conversion complete strobe |
| conv_code_i | input | CODE_W | Raw converter code, valid with conv_done_i |
| irq_o | output | 1 | Data-ready interrupt |

## Verification
A software clear of a status bit can land on the same clock edge as the hardware setting that bit for a fresh result. The bench provokes this by having its converter model issue a write-one-to-clear for channel 2 on the exact edge at which the final averaged sample of that channel is committed. It then requires the bit to still read as set. Random converter codes feed a bench-side averaging and clamping model, which predicts every stored result. The bench also checks channel order and round spacing at each conversion request.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int A_CFG  = 0;
  localparam int A_CHEN = 1;
  localparam int A_IVAL = 2;
  localparam int A_FILT = 3;
  localparam int A_IEN  = 4;
  localparam int A_STAT = 5;
  localparam int A_CAL  = 8;
  localparam int A_DATA = 16;

  localparam logic [31:0] CFG_RST = 32'h01DF_002F;
  localparam int IVAL_LSB = 12;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ACQ,
    S_CONV,
    S_HOLD
  } seq_state_e;
endpackage

// File: rtl/therm_regs.sv
module therm_regs
  import therm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter int AW     = 5,
  parameter int CHW    = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  input  logic                           res_valid_i,
  input  logic [CHW-1:0]                 res_chan_i,
  input  logic [CODE_W-1:0]              res_code_i,
  output logic [15:0]                    acq_m1_o,
  output logic [15:0]                    per_m1_o,
  output logic [NUM_CH-1:0]              ch_en_o,
  output logic [19:0]                    ival_o,
  output logic                           filt_en_o,
  output logic [1:0]                     filt_type_o,
  output logic [NUM_CH-1:0]              ie_o,
  output logic [NUM_CH-1:0]              stat_o,
  output logic [NUM_CH-1:0][CODE_W-1:0]  cal_o,
  output logic                           irq_o
);
  localparam logic [CODE_W-1:0] CAL_MID = CODE_W'(1) << (CODE_W - 1);

  logic [31:0]                   cfg_q;
  logic [NUM_CH-1:0]             chen_q, ie_q, stat_q;
  logic [19:0]                   ival_q;
  logic [2:0]                    filt_q;
  logic [NUM_CH-1:0][CODE_W-1:0] cal_q, data_q;
  logic                          wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      chen_q <= '0;
      ival_q <= '0;
      filt_q <= '0;
      ie_q   <= '0;
    end else if (wr) begin
      if (addr_i == AW'(A_CFG))  cfg_q  <= wdata_i;
      if (addr_i == AW'(A_CHEN)) chen_q <= wdata_i[NUM_CH-1:0];
      if (addr_i == AW'(A_IVAL)) ival_q <= wdata_i[IVAL_LSB +: 20];
      if (addr_i == AW'(A_FILT)) filt_q <= wdata_i[2:0];
      if (addr_i == AW'(A_IEN))  ie_q   <= wdata_i[NUM_CH-1:0];
    end
  end

  // per-channel state; a fresh result beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) begin
        cal_q[i]  <= CAL_MID;
        data_q[i] <= '0;
      end
      stat_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr && addr_i == AW'(A_CAL + i / 2))
          cal_q[i] <= wdata_i[16*(i%2) +: CODE_W];
        if (res_valid_i && res_chan_i == CHW'(i)) begin
          data_q[i] <= res_code_i;
          stat_q[i] <= 1'b1;
        end else if (wr && addr_i == AW'(A_STAT) && wdata_i[i]) begin
          stat_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_CFG))  rdata_o = cfg_q;
    if (addr_i == AW'(A_CHEN)) rdata_o[NUM_CH-1:0] = chen_q;
    if (addr_i == AW'(A_IVAL)) rdata_o[IVAL_LSB +: 20] = ival_q;
    if (addr_i == AW'(A_FILT)) rdata_o[2:0] = filt_q;
    if (addr_i == AW'(A_IEN))  rdata_o[NUM_CH-1:0] = ie_q;
    if (addr_i == AW'(A_STAT)) rdata_o[NUM_CH-1:0] = stat_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == AW'(A_CAL + i / 2)) rdata_o[16*(i%2) +: CODE_W] = cal_q[i];
      if (addr_i == AW'(A_DATA + i))    rdata_o[CODE_W-1:0] = data_q[i];
    end
  end

  assign acq_m1_o    = cfg_q[15:0];
  assign per_m1_o    = cfg_q[31:16];
  assign ch_en_o     = chen_q;
  assign ival_o      = ival_q;
  assign filt_en_o   = filt_q[2];
  assign filt_type_o = filt_q[1:0];
  assign ie_o        = ie_q;
  assign stat_o      = stat_q;
  assign cal_o       = cal_q;
  assign irq_o       = |(stat_q & ie_q);
endmodule

// File: rtl/therm_interval.sv
module therm_interval #(
  parameter int UNIT_LOG2 = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic [19:0] field_i,
  input  logic [2:0]  shift_i,
  output logic        tick_o
);
  localparam int CW = 20 + UNIT_LOG2 + 5;

  logic [CW-1:0] cnt_q, lim, lim_m1;
  logic          hit;

  assign lim    = (CW'(field_i) + CW'(1)) << (UNIT_LOG2 + int'(shift_i));
  assign lim_m1 = lim - CW'(1);
  assign hit    = cnt_q >= lim_m1;
  assign tick_o = run_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (hit)     cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/therm_conv_seq.sv
module therm_conv_seq
  import therm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter int CHW    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [NUM_CH-1:0]             ch_en_i,
  input  logic [15:0]                   acq_m1_i,
  input  logic [15:0]                   per_m1_i,
  input  logic [2:0]                    shift_i,
  input  logic [NUM_CH-1:0][CODE_W-1:0] cal_i,
  input  logic                          conv_done_i,
  input  logic [CODE_W-1:0]             conv_code_i,
  output logic                          conv_start_o,
  output logic [CHW-1:0]                conv_chan_o,
  output logic                          res_valid_o,
  output logic [CHW-1:0]                res_chan_o,
  output logic [CODE_W-1:0]             res_code_o
);
  localparam int SW = CODE_W + 5;
  localparam int XW = CODE_W + 2;
  localparam logic [XW-1:0] MID = XW'(1) << (CODE_W - 1);

  seq_state_e        st_q;
  logic              pend_q, start_q, rv_q;
  logic [NUM_CH-1:0] en_snap_q;
  logic [2:0]        sh_q;
  logic [CHW-1:0]    chan_q, rchan_q;
  logic [4:0]        samp_q, nsamp_m1;
  logic [SW-1:0]     sum_q, sum_nx, avg;
  logic [15:0]       tmr_q;
  logic [CODE_W-1:0] rcode_q, sat;
  logic [XW-1:0]     adj;
  logic              first_found, nxt_found;
  logic [CHW-1:0]    first_idx, nxt_idx;

  // lowest enabled channel overall, and lowest enabled above the current one
  always_comb begin
    first_found = 1'b0;
    first_idx   = '0;
    nxt_found   = 1'b0;
    nxt_idx     = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ch_en_i[i]) begin
        first_found = 1'b1;
        first_idx   = CHW'(i);
      end
      if (en_snap_q[i] && i > int'(chan_q)) begin
        nxt_found = 1'b1;
        nxt_idx   = CHW'(i);
      end
    end
  end

  assign nsamp_m1 = (5'd1 << sh_q) - 5'd1;
  assign sum_nx   = sum_q + SW'(conv_code_i);
  assign avg      = sum_nx >> sh_q;
  assign adj      = {2'b00, avg[CODE_W-1:0]} + {2'b00, cal_i[chan_q]} - MID;

  always_comb begin
    if (adj[XW-1])       sat = '0;
    else if (adj[XW-2])  sat = '1;
    else                 sat = adj[CODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      pend_q    <= 1'b0;
      start_q   <= 1'b0;
      rv_q      <= 1'b0;
      en_snap_q <= '0;
      sh_q      <= '0;
      chan_q    <= '0;
      rchan_q   <= '0;
      rcode_q   <= '0;
      samp_q    <= '0;
      sum_q     <= '0;
      tmr_q     <= '0;
    end else begin
      start_q <= 1'b0;
      rv_q    <= 1'b0;
      if (tmr_q != '1) tmr_q <= tmr_q + 16'd1;
      if (tick_i) pend_q <= 1'b1;
      unique case (st_q)
        S_IDLE: begin
          if (pend_q) begin
            pend_q    <= tick_i;
            en_snap_q <= ch_en_i;
            sh_q      <= shift_i;
            if (first_found) begin
              chan_q <= first_idx;
              samp_q <= '0;
              sum_q  <= '0;
              tmr_q  <= '0;
              st_q   <= S_ACQ;
            end
          end
        end
        S_ACQ: begin
          if (tmr_q >= acq_m1_i) begin
            start_q <= 1'b1;
            st_q    <= S_CONV;
          end
        end
        S_CONV: begin
          if (conv_done_i) begin
            if (samp_q == nsamp_m1) begin
              rv_q    <= 1'b1;
              rchan_q <= chan_q;
              rcode_q <= sat;
              samp_q  <= '0;
              sum_q   <= '0;
            end else begin
              samp_q <= samp_q + 5'd1;
              sum_q  <= sum_nx;
            end
            st_q <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (tmr_q >= per_m1_i) begin
            tmr_q <= '0;
            if (samp_q != '0) begin
              st_q <= S_ACQ;
            end else if (nxt_found) begin
              chan_q <= nxt_idx;
              st_q   <= S_ACQ;
            end else begin
              st_q <= S_IDLE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign conv_start_o = start_q;
  assign conv_chan_o  = chan_q;
  assign res_valid_o  = rv_q;
  assign res_chan_o   = rchan_q;
  assign res_code_o   = rcode_q;
endmodule

// File: rtl/therm_seq_ctrl.sv
module therm_seq_ctrl
  import therm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CODE_W    = 12,
  parameter int AW        = 5,
  parameter int UNIT_LOG2 = 12,
  parameter int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              conv_start_o,
  output logic [CHW-1:0]    conv_chan_o,
  input  logic              conv_done_i,
  input  logic [CODE_W-1:0] conv_code_i,
  output logic              irq_o
);
  logic                          res_valid;
  logic [CHW-1:0]                res_chan;
  logic [CODE_W-1:0]             res_code;
  logic [15:0]                   acq_m1_w, per_m1_w;
  logic [NUM_CH-1:0]             ch_en_w, ie_w, stat_w;
  logic [19:0]                   ival_w;
  logic                          filt_en_w, tick_w;
  logic [1:0]                    filt_type_w;
  logic [2:0]                    shift_w;
  logic [NUM_CH-1:0][CODE_W-1:0] cal_w;

  assign shift_w = filt_en_w ? ({1'b0, filt_type_w} + 3'd1) : 3'd0;

  therm_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .AW(AW), .CHW(CHW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .res_valid_i (res_valid),
    .res_chan_i  (res_chan),
    .res_code_i  (res_code),
    .acq_m1_o    (acq_m1_w),
    .per_m1_o    (per_m1_w),
    .ch_en_o     (ch_en_w),
    .ival_o      (ival_w),
    .filt_en_o   (filt_en_w),
    .filt_type_o (filt_type_w),
    .ie_o        (ie_w),
    .stat_o      (stat_w),
    .cal_o       (cal_w),
    .irq_o
  );

  therm_interval #(.UNIT_LOG2(UNIT_LOG2)) u_ival (
    .clk_i, .rst_ni,
    .run_i   (|ch_en_w),
    .field_i (ival_w),
    .shift_i (shift_w),
    .tick_o  (tick_w)
  );

  therm_conv_seq #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .CHW(CHW)) u_seq (
    .clk_i, .rst_ni,
    .tick_i      (tick_w),
    .ch_en_i     (ch_en_w),
    .acq_m1_i    (acq_m1_w),
    .per_m1_i    (per_m1_w),
    .shift_i     (shift_w),
    .cal_i       (cal_w),
    .conv_done_i,
    .conv_code_i,
    .conv_start_o,
    .conv_chan_o,
    .res_valid_o (res_valid),
    .res_chan_o  (res_chan),
    .res_code_o  (res_code)
  );
endmodule

// File: rtl/therm_seq_ctrl_chk.sv
module therm_seq_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int CHW    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_start_o,
  input logic [CHW-1:0]    conv_chan_o,
  input logic              irq_o,
  input logic              res_valid,
  input logic [CHW-1:0]    res_chan,
  input logic [NUM_CH-1:0] ie_w,
  input logic [NUM_CH-1:0] stat_w,
  input logic [15:0]       per_m1_w
);
  logic [16:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (conv_start_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 17'd1;
    end
  end

  a_r9_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  a_r9_chan_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> $stable(conv_chan_o));

  a_r2_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && seen_q) |-> (gap_q >= {1'b0, per_m1_w}));

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid |=> stat_w[$past(res_chan)]);

  a_r8_irq_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid && ie_w[res_chan]) |=> irq_o);
endmodule

bind therm_seq_ctrl therm_seq_ctrl_chk #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .irq_o        (irq_o),
  .res_valid    (res_valid),
  .res_chan     (res_chan),
  .ie_w         (ie_w),
  .stat_w       (stat_w),
  .per_m1_w     (per_m1_w)
);

// File: tb/therm_seq_ctrl_tb.sv
module therm_seq_ctrl_tb;
  localparam int NUM_CH = 4;
  localparam int CW     = 12;
  localparam int AW     = 5;
  localparam int UL2    = 6;
  localparam int ACQM1  = 3;
  localparam int PERM1  = 11;
  localparam int W_CFG = 0, W_CHEN = 1, W_IVAL = 2, W_FILT = 3, W_IEN = 4, W_STAT = 5;
  localparam int W_CAL = 8, W_DATA = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic conv_start_o, conv_done_i, irq_o;
  logic [1:0] conv_chan_o;
  logic [CW-1:0] conv_code_i;

  int n_chk = 0, n_bad = 0;
  int unsigned cyc = 0;
  bit finished = 0;

  int mdl_mask, nsamp, shift, exp_iv, prev, code_mode;
  bit have_prev;
  int unsigned last_sweep, last_start;
  int acc [NUM_CH], cnt [NUM_CH], exp_data [NUM_CH], cal [NUM_CH];
  bit collide_arm = 0, collide_hit = 0;
  int a_ch, a_exp, a_code;
  bit a_ns, a_last;

  therm_seq_ctrl #(.NUM_CH(NUM_CH), .CODE_W(CW), .AW(AW), .UNIT_LOG2(UL2)) u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .conv_start_o, .conv_chan_o, .conv_done_i, .conv_code_i, .irq_o
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = AW'(a);
    #1 d = rdata_o;
    req_i = 0;
  endtask

  function automatic int nxt(int mask, int p);
    for (int i = p + 1; i < NUM_CH; i++) if (mask[i]) return i;
    for (int i = 0; i < NUM_CH; i++) if (mask[i]) return i;
    return 0;
  endfunction

  function automatic int clampv(int v);
    if (v < 0) return 0;
    if (v > 4095) return 4095;
    return v;
  endfunction

  // converter model, order/interval checks, result prediction
  initial begin
    conv_done_i = 0;
    conv_code_i = '0;
    forever begin
      @(negedge clk_i);
      if (conv_start_o) begin
        a_ch  = int'(conv_chan_o);
        a_exp = (cnt[prev] != 0) ? prev : nxt(mdl_mask, prev);
        a_ns  = (cnt[prev] == 0) && (a_exp <= prev);
        chk("R5 channel order", a_ch, a_exp);
        if (a_ns) begin
          if (have_prev) chk("R4 round interval", cyc - last_sweep, exp_iv);
          last_sweep = cyc;
          have_prev  = 1;
        end else begin
          chk("R2 conversion spacing", cyc - last_start, PERM1 + 1);
        end
        last_start = cyc;
        prev = a_ch;
        a_code = $urandom & 12'hFFF;
        if (code_mode == 1 && a_ch == 0) a_code = 12'h100;
        if (code_mode == 1 && a_ch == 1) a_code = 12'hF00;
        @(negedge clk_i);
        conv_done_i = 1;
        conv_code_i = CW'(a_code);
        acc[a_ch] += a_code;
        cnt[a_ch]++;
        a_last = (cnt[a_ch] == nsamp);
        if (a_last) begin
          exp_data[a_ch] = clampv((acc[a_ch] >> shift) + cal[a_ch] - 2048);
          acc[a_ch] = 0;
          cnt[a_ch] = 0;
        end
        @(negedge clk_i);
        conv_done_i = 0;
        if (a_last && collide_arm && a_ch == 2) begin
          req_i = 1; we_i = 1; addr_i = AW'(W_STAT); wdata_i = 32'h4;
          @(negedge clk_i);
          req_i = 0; we_i = 0;
          collide_arm = 0;
          collide_hit = 1;
        end
      end
    end
  end

  task automatic start_phase(int mask, int filt, int sh, int field);
    mdl_mask = mask; shift = sh; nsamp = 1 << sh;
    exp_iv = (field + 1) * (1 << UL2) * nsamp;
    prev = NUM_CH - 1; have_prev = 0;
    wr(W_FILT, filt);
    wr(W_IVAL, field << 12);
    wr(W_CHEN, mask);
  endtask

  task automatic end_phase(string tag);
    logic [31:0] d;
    wr(W_CHEN, 0);
    repeat (400) @(negedge clk_i);
    for (int i = 0; i < NUM_CH; i++) begin
      rd(W_DATA + i, d);
      chk(tag, d, exp_data[i]);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM_CH; i++) begin
      acc[i] = 0; cnt[i] = 0; exp_data[i] = 0; cal[i] = 12'h800;
    end
    mdl_mask = 0; nsamp = 1; shift = 0; prev = NUM_CH - 1; code_mode = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    rd(W_CFG, d);      chk("R1 cfg reset", d, 32'h01DF002F);
    rd(W_CAL, d);      chk("R1 cal0/1 reset", d, 32'h08000800);
    rd(W_CAL + 1, d);  chk("R1 cal2/3 reset", d, 32'h08000800);
    rd(W_STAT, d);     chk("R1 status reset", d, 0);
    for (int i = 0; i < NUM_CH; i++) begin
      rd(W_DATA + i, d); chk("R1 data reset", d, 0);
    end
    chk("R1 irq reset", irq_o, 0);

    wr(W_CFG, (PERM1 << 16) | ACQM1);
    wr(W_IEN, 32'hF);

    // phase A: all channels, 4-sample average, collision on channel 2
    start_phase(4'hF, 3'b101, 2, 0);
    repeat (300) @(negedge clk_i);
    collide_arm = 1;
    while (!collide_hit) @(negedge clk_i);
    rd(W_STAT, d);
    chk("R7 set beats same-cycle clear", d[2], 1'b1);
    repeat (900) @(negedge clk_i);
    end_phase("R3 avg4 result");

    // R7 / R8 status and interrupt
    rd(W_STAT, d);     chk("R7 all set", d, 32'hF);
    wr(W_STAT, 0);
    rd(W_STAT, d);     chk("R7 write 0 ignored", d, 32'hF);
    wr(W_STAT, 32'h1);
    rd(W_STAT, d);     chk("R7 w1c bit0", d, 32'hE);
    chk("R8 irq enabled", irq_o, 1);
    wr(W_IEN, 0);
    chk("R8 irq masked", irq_o, 0);
    wr(W_IEN, 32'h1);
    chk("R8 irq on cleared bit", irq_o, 0);
    wr(W_IEN, 32'h2);
    chk("R8 irq on set bit", irq_o, 1);
    wr(W_STAT, 32'hE);
    chk("R8 irq after clear", irq_o, 0);

    // phase B: channels 0,2, averaging off, disabled channels keep data
    start_phase(4'h5, 3'b001, 0, 0);
    repeat (500) @(negedge clk_i);
    end_phase("R5 masked rounds");
    rd(W_STAT, d);     chk("R5 only enabled set", d, 32'h5);
    wr(W_STAT, 32'hF);

    // phase C: channels 1,3, 2-sample average, calibration upper word
    wr(W_CAL + 1, 32'h07F00810);
    cal[2] = 12'h810; cal[3] = 12'h7F0;
    rd(W_CAL + 1, d);  chk("R6 cal readback", d, 32'h07F00810);
    start_phase(4'hA, 3'b100, 1, 1);
    repeat (1200) @(negedge clk_i);
    end_phase("R6 cal offset");

    // phase D: clamp at both ends, 8-sample average
    code_mode = 1;
    wr(W_CAL, 32'h0FFF0000);
    cal[0] = 0; cal[1] = 12'hFFF;
    start_phase(4'h3, 3'b110, 3, 0);
    repeat (1800) @(negedge clk_i);
    end_phase("R3 avg8 result");
    rd(W_DATA, d);     chk("R6 clamp low", d, 0);
    rd(W_DATA + 1, d); chk("R6 clamp high", d, 32'hFFF);

    finished = 1;
    summary();
    $finish;
  end
endmodule